// File: doc/BRIEF.md
# T1 Superframe Sync Monitor

This block watches the framing bits of a received T1 stream and decides whether the stream is in framing synchronization. An upstream framer already knows where each framing bit sits, so every framing bit arrives as a one-cycle strobe. The strobe carries the bit value, the bit's role (terminal framing, signalling framing, or extended-superframe pattern bit) and the bit's position within its six-bit sequence in the superframe. The monitor compares each selected bit with the pattern it expects.

Synchronization is declared after two complete, error-free superframes. It is withdrawn when errors cluster inside a short sliding window of checked bits, or at once when an external framer reports its own loss of alignment. While the monitor is in sync, it keeps a saturating count of framing errors. While it is out of sync, that count is frozen. Software reads the valid flag to decide whether the error count can be trusted.

Top module: `t1_sf_sync_mon`

## Requirements
- R1: After a synchronous reset, `sync_valid` is 0 and `ferr_count` is 0.
- R2: Role code 0 is a terminal bit, 1 is a signalling bit, 2 is a pattern bit and 3 is never checked. Positions run from 0 to 5, and a strobe at a position above 5 is never checked. Expected values by position 0..5 are: terminal 1,0,1,0,1,0; signalling 0,0,1,1,1 (position 5 has no expected value); pattern 0,0,1,0,1,1. A checked bit whose value differs from its expected value is an error.
- R3: While `ext_oos` is high, `sync_valid` falls on the next cycle and stays low, and superframes received in that time do not count toward acquisition.
- R4: `sync_valid` rises only at a superframe boundary, once two consecutive complete superframes after the previous boundary had no errors in any checked bit. The superframe in progress at reset, at loss of sync or at the end of a veto never counts.
- R5: While in sync, `sync_valid` falls when two of the last four checked bits were errors.
- R6: In SF mode (`esf_mode`=0), all terminal bits are checked. Signalling bits at positions 0 to 4 are checked only when `fs_sel` is 1, and signalling position 5 is never checked. Pattern-bit strobes are ignored. The strobe of signalling position 5 ends the superframe.
- R7: In ESF mode (`esf_mode`=1), only pattern bits are checked, and terminal and signalling strobes have no effect. The strobe of pattern position 5 ends the superframe.
- R8: `ferr_count` increments by one for each erroneous checked bit that arrives while `sync_valid` is high, and holds its value while `sync_valid` is low.
- R9: `ferr_count` saturates at its all-ones value.
- R10: `cnt_clr` clears `ferr_count` to 0 on the next cycle, taking priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_stb | input | 1 | One-cycle strobe marking a framing bit |
| fb_val | input | 1 | Received framing bit value |
| fb_role | input | 2 | Role of the bit: 0 terminal, 1 signalling, 2 pattern |
| fb_pos | input | 3 | Position of the bit within its six-bit sequence |
| esf_mode | input | 1 | 1 selects extended superframe checking |
| fs_sel | input | 1 | In SF mode, 1 also checks signalling bits |
| ext_oos | input | 1 | External framer out-of-sync indication |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| sync_valid | output | 1 | Framing synchronization declared; error count valid |
| ferr_count | output | CNT_W | Saturating framing error count |

## Verification
The bench runs all 64 error patterns over the six terminal or pattern positions in each of the three checking modes, and compares the result with an arithmetic model. A window rule that is off by one would lose sync on errors spaced four checked bits apart, or keep it on errors spaced three apart. Junk values are driven on unchecked bits: signalling position 5, signalling bits in terminal-only mode, and terminal and signalling bits in ESF mode. A design that checked any of these would lose sync or count errors the model does not count. Further tests check that the superframe in progress at reset is not counted toward acquisition, that the veto must be followed by fresh clean superframes, that errors are not counted while out of sync, and that the count saturates instead of wrapping.

// File: rtl/t1sync_pkg.sv
package t1sync_pkg;

  localparam int SF_BITS = 6;
  localparam int POS_W   = 3;

  typedef enum logic [1:0] {
    ROLE_FT   = 2'd0,
    ROLE_FS   = 2'd1,
    ROLE_FPS  = 2'd2,
    ROLE_NONE = 2'd3
  } fbit_role_e;

  // Expected framing-bit value for a role at a position in the superframe.
  function automatic logic expected_bit(fbit_role_e r, int p);
    case (r)
      ROLE_FT:  return ((p % 2) == 0);
      ROLE_FS:  return (p >= 2);
      ROLE_FPS: return (p == 2) || (p == 4) || (p == 5);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/t1sync_fbit_chk.sv
module t1sync_fbit_chk
  import t1sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             val,
  input  logic [1:0]       role,
  input  logic [POS_W-1:0] pos,
  input  logic             esf_mode,
  input  logic             fs_sel,
  output logic             chk_vld_o,
  output logic             chk_err_o,
  output logic             sf_end_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SF_BITS - 1);

  fbit_role_e role_e;
  logic       in_range;
  logic       sel_c;
  logic       chk_c;
  logic       err_c;
  logic       end_c;

  always_comb begin
    role_e   = fbit_role_e'(role);
    in_range = (pos <= LAST_POS);
    if (esf_mode)
      sel_c = (role_e == ROLE_FPS);
    else
      sel_c = (role_e == ROLE_FT) ||
              (fs_sel && (role_e == ROLE_FS) && (pos != LAST_POS));
    chk_c = stb && in_range && sel_c;
    err_c = chk_c && (val != expected_bit(role_e, int'(pos)));
    end_c = stb && (pos == LAST_POS) &&
            (esf_mode ? (role_e == ROLE_FPS) : (role_e == ROLE_FS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_vld_o <= 1'b0;
      chk_err_o <= 1'b0;
      sf_end_o  <= 1'b0;
    end else begin
      chk_vld_o <= chk_c;
      chk_err_o <= err_c;
      sf_end_o  <= end_c;
    end
  end

  AST_IDLE_NO_CHECK: assert property (@(posedge clk) disable iff (rst)
    !stb |=> (!chk_vld_o && !sf_end_o)); // R2
  AST_ESF_PATTERN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (esf_mode && stb && (role != 2'd2)) |=> !chk_vld_o); // R7
  AST_FS_LAST_SKIPPED: assert property (@(posedge clk) disable iff (rst)
    (!esf_mode && stb && (role == 2'd1) && (pos == LAST_POS)) |=> (!chk_vld_o && sf_end_o)); // R6

endmodule

// File: rtl/t1sync_fsm.sv
module t1sync_fsm #(
  parameter int ACQ_SF    = 2,
  parameter int LOSS_WIN  = 4,
  parameter int LOSS_ERRS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic chk_vld,
  input  logic chk_err,
  input  logic sf_end,
  input  logic ext_oos,
  output logic sync_o
);

  localparam int GW = $clog2(ACQ_SF + 1);

  logic [LOSS_WIN-1:0] win_q, win_n;
  logic [GW-1:0]       good_q, good_n;
  logic                clean_q, clean_n;
  logic                sync_q, sync_n;

  always_comb begin
    win_n   = win_q;
    good_n  = good_q;
    clean_n = clean_q;
    sync_n  = sync_q;
    if (chk_vld) begin
      win_n = {win_q[LOSS_WIN-2:0], chk_err};
      if (chk_err)
        clean_n = 1'b0;
      if (sync_q && ($countones(win_n) >= LOSS_ERRS)) begin
        sync_n  = 1'b0;
        good_n  = '0;
        clean_n = 1'b0;
      end
    end
    if (sf_end && !sync_n) begin
      if (clean_n)
        good_n = good_q + GW'(1);
      else
        good_n = '0;
      if (good_n == GW'(ACQ_SF)) begin
        sync_n = 1'b1;
        good_n = '0;
      end
      clean_n = 1'b1;
    end
    if (ext_oos) begin
      sync_n  = 1'b0;
      good_n  = '0;
      clean_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      good_q  <= '0;
      clean_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      win_q   <= win_n;
      good_q  <= good_n;
      clean_q <= clean_n;
      sync_q  <= sync_n;
    end
  end

  assign sync_o = sync_q;

  AST_VETO_DROPS: assert property (@(posedge clk) disable iff (rst)
    ext_oos |=> !sync_q); // R3
  AST_ACQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (!sync_q && !(sf_end && !ext_oos)) |=> !sync_q); // R4
  AST_CLUSTER_LOSS: assert property (@(posedge clk) disable iff (rst)
    (sync_q && chk_vld && chk_err &&
     ($countones({win_q[LOSS_WIN-2:0], 1'b1}) >= LOSS_ERRS)) |=> !sync_q); // R5

endmodule

// File: rtl/t1sync_err_cnt.sv
module t1sync_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             err,
  input  logic             in_sync,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (err && in_sync && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  AST_FROZEN_OOS: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && !clr) |=> $stable(cnt_q)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == CNT_MAX) && !clr) |=> (cnt_q == CNT_MAX)); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/t1_sf_sync_mon.sv
module t1_sf_sync_mon
  import t1sync_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ACQ_SF    = 2,
  parameter int LOSS_WIN  = 4,
  parameter int LOSS_ERRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_stb,
  input  logic             fb_val,
  input  logic [1:0]       fb_role,
  input  logic [2:0]       fb_pos,
  input  logic             esf_mode,
  input  logic             fs_sel,
  input  logic             ext_oos,
  input  logic             cnt_clr,
  output logic             sync_valid,
  output logic [CNT_W-1:0] ferr_count
);

  logic chk_vld;
  logic chk_err;
  logic sf_end;

  t1sync_fbit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stb       (fb_stb),
    .val       (fb_val),
    .role      (fb_role),
    .pos       (fb_pos),
    .esf_mode  (esf_mode),
    .fs_sel    (fs_sel),
    .chk_vld_o (chk_vld),
    .chk_err_o (chk_err),
    .sf_end_o  (sf_end)
  );

  t1sync_fsm #(
    .ACQ_SF    (ACQ_SF),
    .LOSS_WIN  (LOSS_WIN),
    .LOSS_ERRS (LOSS_ERRS)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .chk_vld (chk_vld),
    .chk_err (chk_err),
    .sf_end  (sf_end),
    .ext_oos (ext_oos),
    .sync_o  (sync_valid)
  );

  t1sync_err_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .err     (chk_vld && chk_err),
    .in_sync (sync_valid),
    .count_o (ferr_count)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!sync_valid && (ferr_count == '0))); // R1

endmodule

// File: tb/t1_sf_sync_mon_test.sv
module t1_sf_sync_mon_test;

  localparam int CW   = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, stb, val, esf, fsel, ext, clr;
  logic [1:0] role;
  logic [2:0] pos;
  logic sync_v;
  logic [CW-1:0] cnt;

  always #10 clk = ~clk;

  t1_sf_sync_mon #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .fb_stb(stb), .fb_val(val), .fb_role(role),
    .fb_pos(pos), .esf_mode(esf), .fs_sel(fsel), .ext_oos(ext),
    .cnt_clr(clr), .sync_valid(sync_v), .ferr_count(cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit m_sync, m_clean, m_ext;
  int m_good, m_cnt;
  logic [3:0] m_win;

  function automatic bit exp_bit(int r, int p);
    if (r == 0) return (p % 2) == 0;
    if (r == 1) return p >= 2;
    if (r == 2) return (p == 2) || (p == 4) || (p == 5);
    return 1'b0;
  endfunction

  function automatic bit is_checked(int r, int p);
    if (p > 5) return 1'b0;
    if (esf) return r == 2;
    return (r == 0) || (fsel && r == 1 && p != 5);
  endfunction

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " sync"}, int'(sync_v), int'(m_sync));
    check({tag, " count"}, int'(cnt), m_cnt);
  endtask

  task automatic model_veto();
    m_sync = 0; m_good = 0; m_clean = 0;
  endtask

  task automatic model_step(int r, int p, bit v);
    bit err;
    bit sfend;
    sfend = (p == 5) && (esf ? (r == 2) : (r == 1));
    if (is_checked(r, p)) begin
      err = (v != exp_bit(r, p));
      if (m_sync && err && m_cnt != MAXC) m_cnt++;
      m_win = {m_win[2:0], err};
      if (err) m_clean = 0;
      if (m_sync && $countones(m_win) >= 2) begin
        m_sync = 0; m_good = 0; m_clean = 0;
      end
    end
    if (sfend && !m_sync) begin
      if (m_clean) m_good++; else m_good = 0;
      if (m_good == 2) begin m_sync = 1; m_good = 0; end
      m_clean = 1;
    end
    if (m_ext) model_veto();
  endtask

  task automatic strobe(int r, int p, bit v);
    @(negedge clk);
    stb = 1'b1; role = r[1:0]; pos = p[2:0]; val = v;
    model_step(r, p, v);
    @(negedge clk);
    stb = 1'b0;
  endtask

  // One superframe; em flips terminal (SF) or pattern (ESF) bits by position.
  task automatic send_sf(logic [5:0] em);
    for (int i = 0; i < 6; i++) begin
      if (esf) begin
        strobe(0, i, !exp_bit(0, i));
        strobe(1, i, !exp_bit(1, i));
        strobe(2, i, exp_bit(2, i) ^ em[i]);
      end else begin
        strobe(0, i, exp_bit(0, i) ^ em[i]);
        if (fsel) strobe(1, i, (i == 5) ? !exp_bit(1, i) : exp_bit(1, i));
        else      strobe(1, i, !exp_bit(1, i));
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; stb = 1'b0; ext = 1'b0; clr = 1'b0; m_ext = 0;
    val = 1'b0; role = 2'd0; pos = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_sync = 0; m_good = 0; m_clean = 0; m_win = '0; m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic acquire();
    repeat (4) if (!m_sync) send_sf(6'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    esf = 1'b0; fsel = 1'b1;
    do_reset();
    check("R1 reset sync", int'(sync_v), 0);
    check("R1 reset count", int'(cnt), 0);

    for (int mode = 0; mode < 3; mode++) begin
      esf  = (mode == 2);
      fsel = (mode == 0);
      do_reset();
      // R8: errors while out of sync are not counted
      send_sf(6'h3f);
      check_state($sformatf("R8 frozen mode %0d", mode));
      check("R8 frozen value", int'(cnt), 0);
      // R4: acquisition needs two clean superframes after a boundary
      send_sf(6'd0);
      check_state($sformatf("R4 first clean mode %0d", mode));
      check("R4 not yet", int'(sync_v), 0);
      send_sf(6'd0);
      check_state($sformatf("R4 second clean mode %0d", mode));
      check("R4 acquired", int'(sync_v), 1);
      // R5 R6 R7 R8: every error pattern over six positions
      for (int mask = 0; mask < 64; mask++) begin
        acquire();
        send_sf(mask[5:0]);
        check_state($sformatf("R5 R6 R7 mode %0d mask %0d", mode, mask));
      end
      // R3: external veto
      acquire();
      @(negedge clk); ext = 1'b1; m_ext = 1; model_veto();
      repeat (2) @(negedge clk);
      check("R3 veto drops", int'(sync_v), 0);
      send_sf(6'd0);
      send_sf(6'd0);
      check_state($sformatf("R3 held mode %0d", mode));
      check("R3 held low", int'(sync_v), 0);
      @(negedge clk); ext = 1'b0; m_ext = 0;
      send_sf(6'd0);
      check_state("R3 after veto 1");
      send_sf(6'd0);
      check_state("R3 after veto 2");
      send_sf(6'd0);
      check_state("R3 after veto 3");
      check("R3 R4 reacquired", int'(sync_v), 1);
      // R10: clear
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0; m_cnt = 0;
      @(negedge clk);
      check("R10 clear", int'(cnt), 0);
      // R9: saturation with isolated errors
      acquire();
      repeat (70) send_sf(6'b000001);
      check_state($sformatf("R9 sat mode %0d", mode));
      check("R9 at max", int'(cnt), MAXC);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule